// File: doc/BRIEF.md
# NOR flash command sequence decoder

This block sits between a flash device's bus write port and its embedded program and erase engines. It watches single-cycle write strobes (address, data, and a sector index supplied by an external address decoder). It recognises the multi-write unlock sequences that guard every state-changing command. Recognised commands come out as one-cycle start pulses for a program, a chip erase or a sector erase. A program pulse carries the latched target address and data word.

Sector erase collects sectors during a collection window. Each further sector-erase write sets a bit in a sector bitmap and restarts a cycle counter. The erase is launched only when the counter runs out with no further write. A suspend command can cut the window short or pause a running sector erase. While paused, the host may program other locations and then resume. An unlock-bypass mode shortens each program to two writes. The embedded algorithms are modelled outside the block: the decoder enters a busy state on a start pulse and leaves it on a one-cycle `alg_done` input.

Top module: `nor_cmd_decoder`

## Requirements
- R1: After reset, `mode` is 0 (array read), `erase_map` is all zeros, `erase_hold` is 0, and no start pulse is asserted.
- R2: The sequence AAh@555h, 55h@2AAh, A0h@555h, then one write of (address, data) produces a one-cycle `start_program` with `prog_addr`/`prog_data` equal to that write, and moves `mode` to 4 (program busy). Writes are ignored while busy, and `alg_done` returns `mode` to the state the program was issued from. Command addresses compare only the low 11 address bits and command codes only the low 8 data bits.
- R3: A write that breaks the expected unlock pattern (wrong address or wrong data) discards the partial sequence and returns `mode` to 0; the writes that follow are not taken as part of a command.
- R4: AAh@555h, 55h@2AAh, 80h@555h, AAh@555h, 55h@2AAh, 10h@555h produces one `start_chip_erase` pulse and `mode` 5 (erase busy). `alg_done` returns `mode` to 0.
- R5: The same five-write prefix followed by 30h at any address opens the collection window (`mode` 3) and sets bit `wr_sector` of `erase_map`. Every further 30h write in the window sets its sector bit and restarts the window. `start_sector_erase` is asserted exactly WINDOW_CYC cycles after the clock edge that captured the last 30h write, and `mode` becomes 5 in that cycle.
- R6: Any write other than 30h or B0h during the window returns `mode` to 0, clears `erase_map` and produces no start pulse.
- R7: B0h at any address suspends (`mode` 6, `erase_hold` 1) only while the window is open or a sector erase is busy. It ends the window at once, with no erase start. It is ignored in any other state, including chip-erase busy and an already suspended state.
- R8: While suspended, a standard program sequence produces `start_program` and `mode` 7; `alg_done` returns `mode` to 6. 30h at any address resumes (`mode` 5, `erase_hold` 0). The first resume after a window that was cut short issues `start_sector_erase` with the collected map; later resumes issue no pulse. Suspend and resume may repeat.
- R9: AAh@555h, 55h@2AAh, 20h@555h enters unlock bypass (`mode` 2). There, A0h at any address followed by an (address, data) write starts a program, and after `alg_done` `mode` returns to 2. The pair 90h then 00h at any address exits to `mode` 0.
- R10: F0h at any address returns `mode` to 0 from array read or ID read. AAh@555h, 55h@2AAh, 90h@555h enters ID read (`mode` 1).
- R11: At most one of the three start pulses is asserted in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One-cycle bus write strobe |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | DATA_W | Write data |
| wr_sector | input | SECT_W | Sector index of `wr_addr` from an external decoder |
| alg_done | input | 1 | One-cycle completion of the running embedded algorithm |
| start_program | output | 1 | Program start pulse |
| prog_addr | output | ADDR_W | Latched program address |
| prog_data | output | DATA_W | Latched program data |
| start_chip_erase | output | 1 | Chip erase start pulse |
| start_sector_erase | output | 1 | Sector erase start pulse |
| erase_map | output | NUM_SECT | Sectors selected for the pending or running sector erase |
| erase_hold | output | 1 | High while a sector erase is suspended |
| mode | output | 3 | 0 read, 1 ID read, 2 bypass, 3 window, 4 program busy, 5 erase busy, 6 suspended, 7 program in suspend |

## Verification
The hardest case to reach is a resume from a suspend that was issued inside the collection window. The erase never started there, so the resume itself must launch it with the map gathered before the suspend. The bench gets there by opening a window and entering a program-in-suspend round trip while suspended. It then waits well past the window length to show nothing was launched, and only then resumes. A second suspend/resume round follows, checking that no second launch appears. The window's exact expiry cycle is checked separately after an extending write. A scoreboard queue of expected start pulses catches any pulse that is unexpected or out of order.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

    localparam int CMD_AW = 11;

    localparam logic [CMD_AW-1:0] ADR_FIRST  = 11'h555;
    localparam logic [CMD_AW-1:0] ADR_SECOND = 11'h2AA;

    localparam logic [7:0] K_KEY_A    = 8'hAA;
    localparam logic [7:0] K_KEY_B    = 8'h55;
    localparam logic [7:0] K_PROG     = 8'hA0;
    localparam logic [7:0] K_ERSETUP  = 8'h80;
    localparam logic [7:0] K_CHIP     = 8'h10;
    localparam logic [7:0] K_SECTOR   = 8'h30;
    localparam logic [7:0] K_SUSPEND  = 8'hB0;
    localparam logic [7:0] K_BYPASS   = 8'h20;
    localparam logic [7:0] K_IDENT    = 8'h90;
    localparam logic [7:0] K_BYP_EXIT = 8'h00;
    localparam logic [7:0] K_RESET    = 8'hF0;

    typedef enum logic [2:0] {
        M_READ      = 3'd0,
        M_IDENT     = 3'd1,
        M_BYPASS    = 3'd2,
        M_WINDOW    = 3'd3,
        M_PROG      = 3'd4,
        M_ERASE     = 3'd5,
        M_SUSP      = 3'd6,
        M_SUSP_PROG = 3'd7
    } mode_e;

    typedef enum logic [2:0] {
        Q_IDLE,
        Q_KEY1,
        Q_KEY2,
        Q_ER3,
        Q_ER4,
        Q_ER5,
        Q_PADDR,
        Q_BYPX
    } seq_e;

    typedef struct packed {
        logic key_a;
        logic key_b;
        logic cmd_slot;
    } wr_class_t;

endpackage

// File: rtl/nor_cmd_classify.sv
module nor_cmd_classify
    import nor_cmd_pkg::*;
(
    input  logic [CMD_AW-1:0] addr_lo,
    input  logic [7:0]        code,
    output wr_class_t         cls
);
    always_comb begin
        cls.cmd_slot = (addr_lo == ADR_FIRST);
        cls.key_a    = (addr_lo == ADR_FIRST)  && (code == K_KEY_A);
        cls.key_b    = (addr_lo == ADR_SECOND) && (code == K_KEY_B);
    end
endmodule

// File: rtl/nor_sector_select.sv
module nor_sector_select #(
    parameter int NUM_SECT = 11,
    parameter int SECT_W   = 4
) (
    input  logic [SECT_W-1:0]   sect_idx,
    output logic [NUM_SECT-1:0] sect_bit
);
    for (genvar g = 0; g < NUM_SECT; g++) begin : g_dec
        assign sect_bit[g] = (sect_idx == SECT_W'(g));
    end
endmodule

// File: rtl/nor_window_timer.sv
module nor_window_timer #(
    parameter int WINDOW_CYC = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic clear,
    output logic expire
);
    localparam int CW = $clog2(WINDOW_CYC + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear)
            cnt_d = '0;
        else if (load)
            cnt_d = CW'(WINDOW_CYC);
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end

    assign expire = (cnt_q == CW'(1));
endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder
    import nor_cmd_pkg::*;
#(
    parameter int ADDR_W     = 18,
    parameter int DATA_W     = 16,
    parameter int NUM_SECT   = 11,
    parameter int WINDOW_CYC = 64,
    parameter int SECT_W     = $clog2(NUM_SECT)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0]   wr_data,
    input  logic [SECT_W-1:0]   wr_sector,
    input  logic                alg_done,
    output logic                start_program,
    output logic [ADDR_W-1:0]   prog_addr,
    output logic [DATA_W-1:0]   prog_data,
    output logic                start_chip_erase,
    output logic                start_sector_erase,
    output logic [NUM_SECT-1:0] erase_map,
    output logic                erase_hold,
    output logic [2:0]          mode
);

    typedef struct packed {
        mode_e               mode;
        seq_e                seq;
        mode_e               ret;
        logic                chip;
        logic                started;
        logic [NUM_SECT-1:0] map;
        logic                go_prog;
        logic                go_chip;
        logic                go_sect;
        logic [ADDR_W-1:0]   paddr;
        logic [DATA_W-1:0]   pdata;
    } state_t;

    state_t d, q;

    wr_class_t           cls;
    logic [NUM_SECT-1:0] sect_bit;
    logic                t_load, t_clear, t_expire;
    logic [7:0]          code;

    assign code = wr_data[7:0];

    nor_cmd_classify i_classify (
        .addr_lo (wr_addr[CMD_AW-1:0]),
        .code    (code),
        .cls     (cls)
    );

    nor_sector_select #(
        .NUM_SECT (NUM_SECT),
        .SECT_W   (SECT_W)
    ) i_sect (
        .sect_idx (wr_sector),
        .sect_bit (sect_bit)
    );

    nor_window_timer #(
        .WINDOW_CYC (WINDOW_CYC)
    ) i_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (t_load),
        .clear  (t_clear),
        .expire (t_expire)
    );

    always_comb begin
        d         = q;
        d.go_prog = 1'b0;
        d.go_chip = 1'b0;
        d.go_sect = 1'b0;
        t_load    = 1'b0;
        t_clear   = 1'b0;

        case (q.mode)
            M_READ, M_IDENT: begin
                if (wr_en) begin
                    if (code == K_RESET && q.seq != Q_PADDR) begin
                        d.mode = M_READ;
                        d.seq  = Q_IDLE;
                    end else begin
                        d.mode = M_READ;
                        d.seq  = Q_IDLE;
                        case (q.seq)
                            Q_IDLE: if (cls.key_a) begin
                                d.mode = q.mode;
                                d.seq  = Q_KEY1;
                            end
                            Q_KEY1: if (cls.key_b) begin
                                d.mode = q.mode;
                                d.seq  = Q_KEY2;
                            end
                            Q_KEY2: if (cls.cmd_slot) begin
                                if (code == K_PROG) begin
                                    d.mode = q.mode;
                                    d.seq  = Q_PADDR;
                                    d.ret  = M_READ;
                                end else if (code == K_ERSETUP) begin
                                    d.mode = q.mode;
                                    d.seq  = Q_ER3;
                                end else if (code == K_BYPASS) begin
                                    d.mode = M_BYPASS;
                                end else if (code == K_IDENT) begin
                                    d.mode = M_IDENT;
                                end
                            end
                            Q_PADDR: begin
                                d.mode    = M_PROG;
                                d.go_prog = 1'b1;
                                d.paddr   = wr_addr;
                                d.pdata   = wr_data;
                            end
                            Q_ER3: if (cls.key_a) begin
                                d.mode = q.mode;
                                d.seq  = Q_ER4;
                            end
                            Q_ER4: if (cls.key_b) begin
                                d.mode = q.mode;
                                d.seq  = Q_ER5;
                            end
                            Q_ER5: begin
                                if (cls.cmd_slot && code == K_CHIP) begin
                                    d.mode    = M_ERASE;
                                    d.go_chip = 1'b1;
                                    d.chip    = 1'b1;
                                    d.started = 1'b1;
                                end else if (code == K_SECTOR) begin
                                    d.mode    = M_WINDOW;
                                    d.chip    = 1'b0;
                                    d.started = 1'b0;
                                    d.map     = sect_bit;
                                    t_load    = 1'b1;
                                end
                            end
                            default: ;
                        endcase
                    end
                end
            end

            M_BYPASS: begin
                if (wr_en) begin
                    case (q.seq)
                        Q_PADDR: begin
                            d.mode    = M_PROG;
                            d.seq     = Q_IDLE;
                            d.go_prog = 1'b1;
                            d.paddr   = wr_addr;
                            d.pdata   = wr_data;
                        end
                        Q_BYPX: begin
                            d.seq = Q_IDLE;
                            if (code == K_BYP_EXIT)
                                d.mode = M_READ;
                        end
                        default: begin
                            if (code == K_PROG) begin
                                d.seq = Q_PADDR;
                                d.ret = M_BYPASS;
                            end else if (code == K_IDENT) begin
                                d.seq = Q_BYPX;
                            end
                        end
                    endcase
                end
            end

            M_WINDOW: begin
                if (wr_en) begin
                    if (code == K_SECTOR) begin
                        d.map  = q.map | sect_bit;
                        t_load = 1'b1;
                    end else if (code == K_SUSPEND) begin
                        d.mode  = M_SUSP;
                        t_clear = 1'b1;
                    end else begin
                        d.mode  = M_READ;
                        d.map   = '0;
                        t_clear = 1'b1;
                    end
                end else if (t_expire) begin
                    d.mode    = M_ERASE;
                    d.go_sect = 1'b1;
                    d.started = 1'b1;
                    t_clear   = 1'b1;
                end
            end

            M_PROG: begin
                if (alg_done)
                    d.mode = q.ret;
            end

            M_SUSP_PROG: begin
                if (alg_done)
                    d.mode = M_SUSP;
            end

            M_ERASE: begin
                if (alg_done) begin
                    d.mode    = M_READ;
                    d.map     = '0;
                    d.chip    = 1'b0;
                    d.started = 1'b0;
                end else if (wr_en && code == K_SUSPEND && !q.chip) begin
                    d.mode = M_SUSP;
                end
            end

            M_SUSP: begin
                if (wr_en) begin
                    d.seq = Q_IDLE;
                    if (q.seq == Q_PADDR) begin
                        d.mode    = M_SUSP_PROG;
                        d.go_prog = 1'b1;
                        d.paddr   = wr_addr;
                        d.pdata   = wr_data;
                    end else if (code != K_RESET) begin
                        case (q.seq)
                            Q_IDLE: begin
                                if (code == K_SECTOR) begin
                                    d.mode = M_ERASE;
                                    if (!q.started) begin
                                        d.go_sect = 1'b1;
                                        d.started = 1'b1;
                                    end
                                end else if (cls.key_a) begin
                                    d.seq = Q_KEY1;
                                end
                            end
                            Q_KEY1: if (cls.key_b) d.seq = Q_KEY2;
                            Q_KEY2: if (cls.cmd_slot && code == K_PROG) begin
                                d.seq = Q_PADDR;
                                d.ret = M_SUSP;
                            end
                            default: ;
                        endcase
                    end
                end
            end

            default: d.mode = M_READ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.mode    <= M_READ;
            q.seq     <= Q_IDLE;
            q.ret     <= M_READ;
            q.chip    <= 1'b0;
            q.started <= 1'b0;
            q.map     <= '0;
            q.go_prog <= 1'b0;
            q.go_chip <= 1'b0;
            q.go_sect <= 1'b0;
            q.paddr   <= '0;
            q.pdata   <= '0;
        end else begin
            q <= d;
        end
    end

    assign start_program      = q.go_prog;
    assign start_chip_erase   = q.go_chip;
    assign start_sector_erase = q.go_sect;
    assign prog_addr          = q.paddr;
    assign prog_data          = q.pdata;
    assign erase_map          = q.map;
    assign erase_hold         = (q.mode == M_SUSP) || (q.mode == M_SUSP_PROG);
    assign mode               = q.mode;

endmodule

// File: rtl/nor_cmd_checker.sv
module nor_cmd_checker #(
    parameter int NUM_SECT = 11
) (
    input logic                clk,
    input logic                rst_n,
    input logic                alg_done,
    input logic                start_program,
    input logic                start_chip_erase,
    input logic                start_sector_erase,
    input logic [NUM_SECT-1:0] erase_map,
    input logic [2:0]          mode
);

    a_r11_single_start: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_program, start_chip_erase, start_sector_erase}));

    a_r2_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd4 && !alg_done) |=> (mode == 3'd4));

    a_r2_prog_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start_program |-> (mode == 3'd4 || mode == 3'd7));

    a_r5_sect_start_src: assert property (@(posedge clk) disable iff (!rst_n)
        start_sector_erase |-> (($past(mode) == 3'd3 || $past(mode) == 3'd6)
                                && erase_map != '0 && mode == 3'd5));

    a_r6_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd0 && $past(mode) == 3'd3) |-> (erase_map == '0));

    a_r7_suspend_src: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'd6 && $past(mode) != 3'd6 && $past(mode) != 3'd7)
            |-> ($past(mode) == 3'd3 || $past(mode) == 3'd5));

    a_r4_chip_enters_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start_chip_erase |-> (mode == 3'd5));

endmodule

bind nor_cmd_decoder nor_cmd_checker #(
    .NUM_SECT (NUM_SECT)
) i_checker (
    .clk                (clk),
    .rst_n              (rst_n),
    .alg_done           (alg_done),
    .start_program      (start_program),
    .start_chip_erase   (start_chip_erase),
    .start_sector_erase (start_sector_erase),
    .erase_map          (erase_map),
    .mode               (mode)
);

// File: tb/test_nor_cmd_decoder.sv
`timescale 1ns/1ps
module test_nor_cmd_decoder;

    localparam int ADDR_W   = 18;
    localparam int DATA_W   = 16;
    localparam int NUM_SECT = 11;
    localparam int WIN      = 8;
    localparam int SECT_W   = $clog2(NUM_SECT);

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic                wr_en = 1'b0;
    logic [ADDR_W-1:0]   wr_addr = '0;
    logic [DATA_W-1:0]   wr_data = '0;
    logic [SECT_W-1:0]   wr_sector = '0;
    logic                alg_done = 1'b0;
    logic                start_program;
    logic [ADDR_W-1:0]   prog_addr;
    logic [DATA_W-1:0]   prog_data;
    logic                start_chip_erase;
    logic                start_sector_erase;
    logic [NUM_SECT-1:0] erase_map;
    logic                erase_hold;
    logic [2:0]          mode;

    int n_checks = 0;
    int n_fail   = 0;
    bit done_run = 1'b0;

    typedef struct {
        int                  kind;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   data;
        logic [NUM_SECT-1:0] map;
        string               req;
    } exp_t;

    exp_t sb[$];

    always #2.5 clk = ~clk;

    nor_cmd_decoder #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (DATA_W),
        .NUM_SECT   (NUM_SECT),
        .WINDOW_CYC (WIN)
    ) i_nor_cmd_decoder (
        .clk                (clk),
        .rst_n              (rst_n),
        .wr_en              (wr_en),
        .wr_addr            (wr_addr),
        .wr_data            (wr_data),
        .wr_sector          (wr_sector),
        .alg_done           (alg_done),
        .start_program      (start_program),
        .prog_addr          (prog_addr),
        .prog_data          (prog_data),
        .start_chip_erase   (start_chip_erase),
        .start_sector_erase (start_sector_erase),
        .erase_map          (erase_map),
        .erase_hold         (erase_hold),
        .mode               (mode)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic push(input int kind, input int addr, input int data,
                        input int map, input string req);
        exp_t e;
        e.kind = kind;
        e.addr = ADDR_W'(addr);
        e.data = DATA_W'(data);
        e.map  = NUM_SECT'(map);
        e.req  = req;
        sb.push_back(e);
    endtask

    // monitor: compares every start pulse with the head of the scoreboard
    always @(negedge clk) begin
        if (rst_n && (start_program || start_chip_erase || start_sector_erase)) begin
            int k;
            k = start_program ? 0 : (start_chip_erase ? 1 : 2);
            if (sb.size() == 0) begin
                chk(1'b0, "R11 unexpected start", k, 99);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(k == e.kind, e.req, k, e.kind);
                if (k == 0) begin
                    chk(prog_addr == e.addr, e.req, int'(prog_addr), int'(e.addr));
                    chk(prog_data == e.data, e.req, int'(prog_data), int'(e.data));
                end
                if (k == 2)
                    chk(erase_map == e.map, e.req, int'(erase_map), int'(e.map));
            end
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic wr(input int a, input int dt, input int s = 0);
        @(negedge clk);
        wr_en     = 1'b1;
        wr_addr   = ADDR_W'(a);
        wr_data   = DATA_W'(dt);
        wr_sector = SECT_W'(s);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic finish_alg();
        @(negedge clk);
        alg_done = 1'b1;
        @(negedge clk);
        alg_done = 1'b0;
    endtask

    task automatic unlock();
        wr('h555, 'hAA);
        wr('h2AA, 'h55);
    endtask

    task automatic erase_prefix();
        unlock();
        wr('h555, 'h80);
        unlock();
    endtask

    task automatic chk_mode(input int exp, input string req);
        chk(mode == 3'(exp), req, int'(mode), exp);
    endtask

    initial begin
        #(100000 * 5);
        chk(1'b0, "watchdog", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk_mode(0, "R1 mode");
        chk(erase_map == '0, "R1 map", int'(erase_map), 0);
        chk(!erase_hold && !start_program && !start_chip_erase && !start_sector_erase,
            "R1 outputs", 1, 0);

        // R2 standard program
        unlock();
        wr('h555, 'hA0);
        push(0, 'h21234, 'hBE5A, 0, "R2 program");
        wr('h21234, 'hBE5A);
        chk_mode(4, "R2 busy");
        unlock();
        wr('h555, 'hA0);
        wr('h0009, 'h0009);
        chk_mode(4, "R2 writes ignored when busy");
        finish_alg();
        chk_mode(0, "R2 return to read");

        // R3 broken prefix (wrong second address) then would-be program
        wr('h555, 'hAA);
        wr('h2AB, 'h55);
        chk_mode(0, "R3 break");
        wr('h555, 'hA0);
        wr('h0100, 'h0011);
        chk_mode(0, "R3 no program");
        // R3 wrong data in third slot; upper address bits ignored (R2)
        wr('h3F555, 'hAA);
        wr('h002AA, 'h55);
        wr('h555, 'h77);
        wr('h0100, 'h0011);
        chk_mode(0, "R3 bad code");

        // R10 ID read and reset
        unlock();
        wr('h555, 'h90);
        chk_mode(1, "R10 id enter");
        wr('h1234, 'hF0);
        chk_mode(0, "R10 reset");

        // R4 chip erase; R7 suspend ignored for chip erase
        erase_prefix();
        push(1, 0, 0, 0, "R4 chip");
        wr('h555, 'h10);
        chk_mode(5, "R4 busy");
        wr('h0, 'hB0);
        chk_mode(5, "R7 no suspend on chip erase");
        chk(!erase_hold, "R7 hold low", int'(erase_hold), 0);
        finish_alg();
        chk_mode(0, "R4 done");

        // R5 window collection and exact expiry
        erase_prefix();
        wr('h4000, 'h30, 3);
        chk_mode(3, "R5 window");
        chk(erase_map == 11'h008, "R5 map first", int'(erase_map), 'h008);
        repeat (4) tick();
        wr('h9000, 'h30, 7);
        chk(erase_map == 11'h088, "R5 map second", int'(erase_map), 'h088);
        push(2, 0, 0, 'h088, "R5 sector start");
        for (int i = 1; i < WIN; i++) begin
            tick();
            chk_mode(3, "R5 still window");
        end
        tick();
        chk_mode(5, "R5 erase after window");
        finish_alg();
        chk_mode(0, "R5 done");
        chk(erase_map == '0, "R5 map cleared", int'(erase_map), 0);

        // R6 abort
        erase_prefix();
        wr('h2000, 'h30, 2);
        wr('h555, 'hAA);
        chk_mode(0, "R6 abort");
        chk(erase_map == '0, "R6 map", int'(erase_map), 0);
        repeat (WIN + 2) tick();
        chk_mode(0, "R6 no start");

        // R7 / R8 suspend inside window
        erase_prefix();
        wr('h1000, 'h30, 1);
        wr('h0, 'hB0);
        chk_mode(6, "R7 suspend");
        chk(erase_hold, "R7 hold", int'(erase_hold), 1);
        repeat (WIN + 2) tick();
        chk_mode(6, "R7 window ended");
        wr('h0, 'hB0);
        chk_mode(6, "R7 repeated suspend");
        unlock();
        wr('h555, 'hA0);
        push(0, 'h30040, 'h0033, 0, "R8 program in suspend");
        wr('h30040, 'h0033);
        chk_mode(7, "R8 suspend program");
        finish_alg();
        chk_mode(6, "R8 back to suspend");
        push(2, 0, 0, 'h002, "R8 resume starts erase");
        wr('h0, 'h30);
        chk_mode(5, "R8 resume");
        chk(!erase_hold, "R8 hold low", int'(erase_hold), 0);
        wr('h0, 'hB0);
        chk_mode(6, "R8 second suspend");
        wr('h0, 'h30);
        chk_mode(5, "R8 second resume");
        finish_alg();
        chk_mode(0, "R8 done");

        // R9 unlock bypass
        unlock();
        wr('h555, 'h20);
        chk_mode(2, "R9 bypass");
        wr('h0, 'hA0);
        push(0, 'h00077, 'h0F0F, 0, "R9 bypass program");
        wr('h00077, 'h0F0F);
        chk_mode(4, "R9 busy");
        finish_alg();
        chk_mode(2, "R9 back to bypass");
        wr('h0, 'h90);
        wr('h0, 'h00);
        chk_mode(0, "R9 exit");

        // R7 suspend in read ignored
        wr('h0, 'hB0);
        chk_mode(0, "R7 ignored in read");

        repeat (3) tick();
        chk(sb.size() == 0, "R11 scoreboard empty", sb.size(), 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule